// File: doc/BRIEF.md
# Palette Lookup Table with Register Write Port

This block holds a 256-entry colour lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue component. A host reaches it through a 16-byte window of 32-bit registers. The host first writes an index register to pick an entry. It then writes the three components of that entry through a single data register, red first, then green, then blue. Every colour byte is taken from the most significant byte of the 32-bit write data.

A small sequencer keeps the current index and a component phase. After the blue component is stored, the index steps to the next entry, wrapping from 255 to 0, so a host can load a run of consecutive entries with an unbroken stream of data writes. A separate combinational lookup port lets a pixel pipeline read any entry as a packed 24-bit colour. Bus reads always return zero. Reset clears every entry to black, except the last entry, which becomes white.

Top module: `palette_ramdac_regs`

## Requirements
- R1: After reset, every entry reads 0x000000 on the lookup port except entry 255, which reads 0xFFFFFF; the index and the phase are zero, so the first data writes land in entry 0.
- R2: The register is selected by address bits [3:2]: 0 is the index register, 1 is the data register, 2 and 3 are unused. Address bits [1:0] are ignored.
- R3: A write to the index register loads the index from write-data bits [31:24] and returns the phase to red. Bits [23:0] are ignored.
- R4: Successive writes to the data register store write-data bits [31:24] into red, then green, then blue of the current entry. Lookup output bits [23:16] are red, [15:8] are green and [7:0] are blue.
- R5: The blue write advances the index by one modulo 256 (255 becomes 0) and returns the phase to red.
- R6: Writes to registers 2 and 3 change no entry, no index and no phase.
- R7: Bus reads return 0 at every address, and a read changes neither the index nor the phase.
- R8: The byte-enable input is ignored. Every write acts as a full 32-bit word, even with all enables low.
- R9: The lookup port is combinational. A write to an entry becomes visible on the following cycle. In the cycle of the write itself, the lookup of that entry still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_be | input | 4 | Byte enables (ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| lk_idx | input | 8 | Lookup entry number |
| lk_rgb | output | 24 | Lookup result {red, green, blue} |

## Verification
Two functions can fall in the same cycle: a component write into an entry, and a lookup of that same entry by the pixel port. The bench provokes this by holding the lookup index on the entry that is being written while it drives the data-register write. It judges the result by requiring the old colour before the clock edge and the new colour after it. A second overlap occurs when a blue write at entry 255 wraps the index to 0. The bench checks that case by sending the next write triple and confirming that it lands in entry 0.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2,
        PH_BAD = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RS_INDEX  = 2'd0,
        RS_DATA   = 2'd1,
        RS_SPARE2 = 2'd2,
        RS_SPARE3 = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic red;
        logic grn;
        logic blu;
    } comp_we_t;

endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              idx_ld,
    output logic              data_wr,
    output logic [IDX_W-1:0]  idx_val,
    output logic [COMP_W-1:0] comp_val
);
    import pal_pkg::*;

    localparam int SEL_LSB = 2;

    reg_sel_e sel;
    logic     unused_bits;

    assign sel         = reg_sel_e'(bus_addr[SEL_LSB+1:SEL_LSB]);
    assign unused_bits = ^{bus_addr[SEL_LSB-1:0], bus_wdata[DATA_W-COMP_W-1:0]};

    always_comb begin
        idx_ld   = 1'b0;
        data_wr  = 1'b0;
        idx_val  = bus_wdata[DATA_W-1 -: IDX_W];
        comp_val = bus_wdata[DATA_W-1 -: COMP_W];
        if (bus_wr) begin
            unique case (sel)
                RS_INDEX: idx_ld  = 1'b1;
                RS_DATA:  data_wr = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/pal_seq.sv
module pal_seq #(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idx_ld,
    input  logic                 data_wr,
    input  logic [IDX_W-1:0]     idx_val,
    output logic [IDX_W-1:0]     cur_idx,
    output pal_pkg::comp_we_t    comp_we
);
    import pal_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           phase;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        comp_we = '0;
        if (idx_ld) begin
            st_d.idx   = idx_val;
            st_d.phase = PH_RED;
        end else if (data_wr) begin
            unique case (st_q.phase)
                PH_RED: begin
                    comp_we.red = 1'b1;
                    st_d.phase  = PH_GRN;
                end
                PH_GRN: begin
                    comp_we.grn = 1'b1;
                    st_d.phase  = PH_BLU;
                end
                PH_BLU: begin
                    comp_we.blu = 1'b1;
                    st_d.idx    = st_q.idx + 1'b1;
                    st_d.phase  = PH_RED;
                end
                default: st_d.phase = PH_RED; // illegal phase: recover, store nothing
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx   <= '0;
            st_q.phase <= PH_RED;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_idx = st_q.idx;

    assert_idx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ld |=> (st_q.idx == $past(idx_val)) && (st_q.phase == PH_RED));

    assert_idx_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !idx_ld && st_q.phase == PH_BLU)
        |=> (st_q.idx == IDX_W'($past(st_q.idx) + 1'b1)) && (st_q.phase == PH_RED));

    assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase != PH_BAD);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_ld && !data_wr) |=> $stable(st_q));

endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      wr_idx,
    input  pal_pkg::comp_we_t     comp_we,
    input  logic [COMP_W-1:0]     comp_val,
    input  logic [IDX_W-1:0]      lk_idx,
    output logic [3*COMP_W-1:0]   lk_rgb
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int RGB_W   = 3 * COMP_W;

    logic [RGB_W-1:0] ent_bus [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam logic [RGB_W-1:0] RST_V = (e == ENTRIES - 1) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
        logic             hit;
        logic [RGB_W-1:0] ent_d, ent_q;

        assign hit = (wr_idx == IDX_W'(e));

        always_comb begin
            ent_d = ent_q;
            if (hit && comp_we.red) ent_d[RGB_W-1 -: COMP_W]    = comp_val;
            if (hit && comp_we.grn) ent_d[2*COMP_W-1 -: COMP_W] = comp_val;
            if (hit && comp_we.blu) ent_d[COMP_W-1:0]           = comp_val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= RST_V;
            else        ent_q <= ent_d;
        end

        assign ent_bus[e] = ent_q;
    end

    assign lk_rgb = ent_bus[lk_idx];

    assert_one_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(comp_we));

    assert_red_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        comp_we.red |=> ent_bus[$past(wr_idx)][RGB_W-1 -: COMP_W] == $past(comp_val));

    assert_blue_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        comp_we.blu |=> ent_bus[$past(wr_idx)][COMP_W-1:0] == $past(comp_val));

endmodule

// File: rtl/palette_ramdac_regs.sv
module palette_ramdac_regs #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [3*COMP_W-1:0] lk_rgb
);
    import pal_pkg::*;

    logic              idx_ld, data_wr;
    logic [IDX_W-1:0]  idx_val, cur_idx;
    logic [COMP_W-1:0] comp_val;
    comp_we_t          comp_we;
    logic              unused_ctl;

    assign unused_ctl = ^{bus_rd, bus_be};
    assign bus_rdata  = '0;

    pal_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .COMP_W(COMP_W)
    ) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .idx_ld(idx_ld), .data_wr(data_wr), .idx_val(idx_val), .comp_val(comp_val)
    );

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .data_wr(data_wr),
        .idx_val(idx_val), .cur_idx(cur_idx), .comp_we(comp_we)
    );

    pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_idx(cur_idx), .comp_we(comp_we),
        .comp_val(comp_val), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
    );

    assert_read_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (!$stable(lk_idx) || $stable(lk_rgb)));

endmodule

// File: tb/palette_ramdac_regs_bench.sv
module palette_ramdac_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lk_idx = '0;
    logic [23:0] lk_rgb;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct { logic [7:0] idx; logic [23:0] rgb; string tag; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    palette_ramdac_regs u_palette_ramdac_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rgb_triple(logic [3:0] a, logic [7:0] r, logic [7:0] g, logic [7:0] b);
        wr(a, {r, 24'h5A5A5A});
        wr(a, {g, 24'hA5A5A5});
        wr(a, {b, 24'h0F0F0F});
    endtask

    task automatic expect_ent(logic [7:0] i, logic [23:0] c, string tag);
        exp_t e;
        e.idx = i; e.rgb = c; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pops expected entries and compares the lookup port
    task automatic monitor_drain();
        while (sb.size() > 0) begin
            exp_t e = sb.pop_front();
            @(negedge clk);
            lk_idx = e.idx;
            #1 check(e.tag, {8'h0, lk_rgb}, {8'h0, e.rgb});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset contents
        expect_ent(8'd0,   24'h000000, "R1 entry0 reset");
        expect_ent(8'd128, 24'h000000, "R1 entry128 reset");
        expect_ent(8'd255, 24'hFFFFFF, "R1 entry255 white");
        monitor_drain();
        // R1 index zero at reset, R4 order, R5 increment
        rgb_triple(4'h4, 8'h11, 8'h22, 8'h33);
        rgb_triple(4'h4, 8'h44, 8'h55, 8'h66);
        expect_ent(8'd0, 24'h112233, "R1 R4 first triple to entry0");
        expect_ent(8'd1, 24'h445566, "R5 auto-increment to entry1");
        monitor_drain();
        // R3 index load, low bits ignored
        wr(4'h0, 32'h10ABCDEF);
        rgb_triple(4'h4, 8'hA0, 8'hB0, 8'hC0);
        expect_ent(8'h10, 24'hA0B0C0, "R3 index load");
        // R3 index write resets phase
        wr(4'h0, 32'h20000000);
        wr(4'h4, 32'h01000000);
        wr(4'h4, 32'h02000000);
        wr(4'h0, 32'h20000000);
        rgb_triple(4'h4, 8'h0A, 8'h0B, 8'h0C);
        expect_ent(8'h20, 24'h0A0B0C, "R3 phase reset");
        expect_ent(8'h21, 24'h000000, "R3 next entry untouched");
        // R2 low address bits ignored
        wr(4'h3, 32'h30000000);
        wr(4'h5, 32'hC1000000);
        wr(4'h6, 32'hC2000000);
        wr(4'h7, 32'hC3000000);
        expect_ent(8'h30, 24'hC1C2C3, "R2 addr[1:0] ignored");
        // R6 spare registers ignored mid-triple
        wr(4'h0, 32'h40000000);
        wr(4'h4, 32'h77000000);
        wr(4'h8, 32'h99999999);
        wr(4'hC, 32'h50000000);
        wr(4'hB, 32'hEE000000);
        wr(4'h4, 32'h88000000);
        wr(4'h4, 32'h99000000);
        rgb_triple(4'h4, 8'h12, 8'h34, 8'h56);
        expect_ent(8'h40, 24'h778899, "R6 spare writes no phase effect");
        expect_ent(8'h41, 24'h123456, "R6 spare writes no index effect");
        expect_ent(8'h50, 24'h000000, "R6 spare write did not load index");
        monitor_drain();
        // R5 wrap from 255 to 0
        wr(4'h0, 32'hFF000000);
        rgb_triple(4'h4, 8'h01, 8'h02, 8'h03);
        rgb_triple(4'h4, 8'h04, 8'h05, 8'h06);
        expect_ent(8'hFF, 24'h010203, "R5 entry255 written");
        expect_ent(8'h00, 24'h040506, "R5 wrap to entry0");
        monitor_drain();
        // R7 reads return zero and do not disturb phase
        wr(4'h0, 32'h60000000);
        wr(4'h4, 32'h61000000);
        for (int a = 0; a < 16; a += 4) begin
            @(negedge clk);
            bus_rd = 1'b1; bus_addr = 4'(a);
            #1 check("R7 read returns zero", bus_rdata, 32'h0);
        end
        @(negedge clk); bus_rd = 1'b0;
        wr(4'h4, 32'h62000000);
        wr(4'h4, 32'h63000000);
        expect_ent(8'h60, 24'h616263, "R7 read no side effect");
        // R8 byte enables ignored
        bus_be = 4'h0;
        wr(4'h0, 32'h70000000);
        rgb_triple(4'h4, 8'hD1, 8'hD2, 8'hD3);
        bus_be = 4'h1;
        rgb_triple(4'h4, 8'hE1, 8'hE2, 8'hE3);
        bus_be = 4'hF;
        expect_ent(8'h70, 24'hD1D2D3, "R8 be=0 write full word");
        expect_ent(8'h71, 24'hE1E2E3, "R8 partial be write full word");
        monitor_drain();
        // R9 same-cycle write and lookup of one entry
        wr(4'h0, 32'h80000000);
        @(negedge clk);
        lk_idx = 8'h80;
        bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h9F000000;
        #1 check("R9 old value during write cycle", {8'h0, lk_rgb}, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R9 new value after edge", {8'h0, lk_rgb}, 32'h009F0000);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule